// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block holds recent virtual-page to physical-page mappings so that most address translations skip the page-table walk. A 48-bit virtual address is split into fields. The 12 least significant bits are the page offset. The next 4 bits pick one of 16 sets. The top 32 bits are the tag that is compared against the 8 ways of that set. A lookup returns, one cycle later, a hit flag and the physical address. That address is the stored page number with the request's page offset appended.

A separate fill port installs a translation after a walk has resolved a miss. The fill goes into the highest-numbered empty way of its set. When the set is full, the way to overwrite is picked by a free-running linear feedback shift register. A fill that carries a zero page number is dropped. A flush input empties the whole array in one cycle.

Top module: `xlat_cache_top`

## Requirements
- R1: A lookup hits only when a valid way of the set named by vaddr[15:12] stores a tag equal to vaddr[47:16]. The same tag in another set, or an invalid way, gives a miss.
- R2: hit_o and paddr_o are registered. They answer the lookup accepted at the previous rising edge. On a hit, paddr_o = {stored page number, vaddr[11:0]}. With a miss or no lookup, hit_o = 0 and paddr_o = 0.
- R3: A fill writes the highest-numbered invalid way of its set, evaluated in the fill cycle. It sets that way valid and stores tag vaddr[47:16] and the supplied page number. Exactly one way is written.
- R4: A fill to a set with no invalid way overwrites the way given by bits [2:0] of a 16-bit shift register. The register resets to 16'hACE1 and shifts left every cycle, inserting at bit 0 the XOR of bits 15, 13, 12 and 10.
- R5: A fill whose page number is zero leaves the array unchanged.
- R6: Reset, active low and asynchronous, clears every valid bit, drives hit_o and paddr_o to 0 and reloads the shift register.
- R7: flush_i clears every valid bit at the next edge. A fill in the same cycle is discarded, and a lookup in the same cycle still sees the old contents.
- R8: When a fill and a lookup occur in the same cycle, the lookup sees the contents from before the fill.
- R9: When several valid ways of a set hold the matching tag, the lowest-numbered one supplies the page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vaddr_i | input | 48 | Lookup virtual address |
| fill_valid_i | input | 1 | Fill request |
| fill_vaddr_i | input | 48 | Virtual address of the fill |
| fill_ppn_i | input | 40 | Physical page number of the fill |
| hit_o | output | 1 | Lookup hit, one cycle after the request |
| paddr_o | output | 52 | Translated physical address |

## Verification
The bench fills one set to capacity and then forces victim replacement. If the victim were chosen from the wrong register bits, or the free-way scan picked the lowest empty way, a later lookup would hit a tag that should be gone or miss one that should remain. A fill and a lookup to the same address in the same cycle must miss, so forwarding the new entry would show up as an early hit. Further tests cover zero-page fills, a flush during traffic, a reset taken in mid-run, and duplicate tags in one set. A wrong priority among duplicates returns the wrong page number. Long stretches of mixed traffic are also run over two crowded sets with a small tag pool.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
  localparam int unsigned DEF_VA_W   = 48;
  localparam int unsigned DEF_OFS_W  = 12;
  localparam int unsigned DEF_IDX_W  = 4;
  localparam int unsigned DEF_WAYS   = 8;
  localparam int unsigned DEF_PPN_W  = 40;
  localparam int unsigned DEF_RND_W  = 16;
  localparam logic [15:0] DEF_SEED   = 16'hACE1;
  localparam logic [15:0] DEF_TAPS   = 16'hB400;
endpackage

// File: rtl/xlat_lfsr.sv
module xlat_lfsr #(
  parameter int unsigned  W    = 16,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {state_q[W-2:0], fb};
  end

  assign state_o = state_q;
endmodule

// File: rtl/xlat_store.sv
module xlat_store #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 8,
  parameter int unsigned TAG_W = 32,
  parameter int unsigned PPN_W = 40,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic [WAYS-1:0]             we_i,
  input  logic [IDX_W-1:0]            wset_i,
  input  logic [TAG_W-1:0]            wtag_i,
  input  logic [PPN_W-1:0]            wppn_i,
  input  logic [IDX_W-1:0]            rset_a_i,
  input  logic [IDX_W-1:0]            rset_b_i,
  output logic [WAYS-1:0]             a_valid_o,
  output logic [WAYS-1:0][TAG_W-1:0]  a_tag_o,
  output logic [WAYS-1:0][PPN_W-1:0]  a_ppn_o,
  output logic [WAYS-1:0]             b_valid_o
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q   [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      for (int w = 0; w < WAYS; w++)
        if (we_i[w]) valid_q[wset_i][w] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int w = 0; w < WAYS; w++) begin
      if (we_i[w]) begin
        tag_q[wset_i][w] <= wtag_i;
        ppn_q[wset_i][w] <= wppn_i;
      end
    end
  end

  assign a_valid_o = valid_q[rset_a_i];
  assign b_valid_o = valid_q[rset_b_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign a_tag_o[w] = tag_q[rset_a_i][w];
    assign a_ppn_o[w] = ppn_q[rset_a_i][w];
  end
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned TAG_W = 32,
  parameter int unsigned PPN_W = 40
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tag_i,
  input  logic [WAYS-1:0][PPN_W-1:0]  ppn_i,
  input  logic [TAG_W-1:0]            req_tag_i,
  output logic                        hit_o,
  output logic [PPN_W-1:0]            ppn_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tag_i[w] == req_tag_i);
  end

  // descending scan: lowest matching way is assigned last and wins
  always_comb begin
    hit_o = |match;
    ppn_o = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) ppn_o = ppn_i[w];
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int unsigned WAYS = 8,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] rnd_i,
  output logic [WAY_W-1:0] way_o
);
  logic             free;
  logic [WAY_W-1:0] free_way;

  // ascending scan: highest invalid way is assigned last and wins
  always_comb begin
    free     = 1'b0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w]) begin
        free     = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  assign way_o = free ? free_way : rnd_i;
endmodule

// File: rtl/xlat_cache_top.sv
module xlat_cache_top
  import xlat_cache_pkg::*;
#(
  parameter int unsigned VA_W  = DEF_VA_W,
  parameter int unsigned OFS_W = DEF_OFS_W,
  parameter int unsigned IDX_W = DEF_IDX_W,
  parameter int unsigned WAYS  = DEF_WAYS,
  parameter int unsigned PPN_W = DEF_PPN_W,
  parameter int unsigned RND_W = DEF_RND_W,
  parameter logic [RND_W-1:0] RND_SEED = RND_W'(DEF_SEED),
  parameter logic [RND_W-1:0] RND_TAPS = RND_W'(DEF_TAPS),
  localparam int unsigned SETS  = 1 << IDX_W,
  localparam int unsigned TAG_W = VA_W - OFS_W - IDX_W,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned PA_W  = PPN_W + OFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             lkp_valid_i,
  input  logic [VA_W-1:0]  lkp_vaddr_i,
  input  logic             fill_valid_i,
  input  logic [VA_W-1:0]  fill_vaddr_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  output logic             hit_o,
  output logic [PA_W-1:0]  paddr_o
);
  logic [IDX_W-1:0] lkp_set, fill_set;
  logic [TAG_W-1:0] lkp_tag, fill_tag;

  assign lkp_set  = lkp_vaddr_i[OFS_W +: IDX_W];
  assign lkp_tag  = lkp_vaddr_i[OFS_W+IDX_W +: TAG_W];
  assign fill_set = fill_vaddr_i[OFS_W +: IDX_W];
  assign fill_tag = fill_vaddr_i[OFS_W+IDX_W +: TAG_W];

  logic [RND_W-1:0] lfsr_val;

  xlat_lfsr #(.W(RND_W), .SEED(RND_SEED), .TAPS(RND_TAPS)) i_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (lfsr_val)
  );

  logic [WAYS-1:0]            a_valid, b_valid, way_we;
  logic [WAYS-1:0][TAG_W-1:0] a_tag;
  logic [WAYS-1:0][PPN_W-1:0] a_ppn;
  logic [WAY_W-1:0]           fill_way;
  logic                       fill_go;

  assign fill_go = fill_valid_i && (fill_ppn_i != '0) && !flush_i;

  for (genvar w = 0; w < WAYS; w++) begin : g_we
    assign way_we[w] = fill_go && (fill_way == WAY_W'(w));
  end

  xlat_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .we_i      (way_we),
    .wset_i    (fill_set),
    .wtag_i    (fill_tag),
    .wppn_i    (fill_ppn_i),
    .rset_a_i  (lkp_set),
    .rset_b_i  (fill_set),
    .a_valid_o (a_valid),
    .a_tag_o   (a_tag),
    .a_ppn_o   (a_ppn),
    .b_valid_o (b_valid)
  );

  xlat_victim #(.WAYS(WAYS)) i_victim (
    .valid_i (b_valid),
    .rnd_i   (lfsr_val[WAY_W-1:0]),
    .way_o   (fill_way)
  );

  logic             m_hit;
  logic [PPN_W-1:0] m_ppn;

  xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) i_match (
    .valid_i   (a_valid),
    .tag_i     (a_tag),
    .ppn_i     (a_ppn),
    .req_tag_i (lkp_tag),
    .hit_o     (m_hit),
    .ppn_o     (m_ppn)
  );

  logic            hit_q;
  logic [PA_W-1:0] paddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      paddr_q <= '0;
    end else if (lkp_valid_i && m_hit) begin
      hit_q   <= 1'b1;
      paddr_q <= {m_ppn, lkp_vaddr_i[OFS_W-1:0]};
    end else begin
      hit_q   <= 1'b0;
      paddr_q <= '0;
    end
  end

  assign hit_o   = hit_q;
  assign paddr_o = paddr_q;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int unsigned VA_W  = 48,
  parameter int unsigned OFS_W = 12,
  parameter int unsigned WAYS  = 8,
  parameter int unsigned PPN_W = 40,
  parameter int unsigned RND_W = 16,
  localparam int unsigned PA_W = PPN_W + OFS_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             lkp_valid_i,
  input logic [VA_W-1:0]  lkp_vaddr_i,
  input logic             fill_valid_i,
  input logic [PPN_W-1:0] fill_ppn_i,
  input logic             hit_o,
  input logic [PA_W-1:0]  paddr_o,
  input logic [WAYS-1:0]  way_we,
  input logic [RND_W-1:0] lfsr_val
);
  // R2
  hit_needs_lookup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(lkp_valid_i));

  // R2
  miss_zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (paddr_o == '0));

  // R2
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (paddr_o[OFS_W-1:0] == $past(lkp_vaddr_i[OFS_W-1:0])));

  // R3
  single_way_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(way_we));

  // R5
  zero_fill_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fill_ppn_i == '0) |-> (way_we == '0));

  // R7
  flush_blocks_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (way_we == '0));

  // R7
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flush_i) && lkp_valid_i) |=> !hit_o);

  // R4
  lfsr_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_val != '0);
endmodule

bind xlat_cache_top xlat_cache_chk #(
  .VA_W(VA_W), .OFS_W(OFS_W), .WAYS(WAYS), .PPN_W(PPN_W), .RND_W(RND_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .lkp_valid_i  (lkp_valid_i),
  .lkp_vaddr_i  (lkp_vaddr_i),
  .fill_valid_i (fill_valid_i),
  .fill_ppn_i   (fill_ppn_i),
  .hit_o        (hit_o),
  .paddr_o      (paddr_o),
  .way_we       (way_we),
  .lfsr_val     (lfsr_val)
);

// File: tb/test_xlat_cache_top.sv
module test_xlat_cache_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        lkp_valid_i = 1'b0;
  logic [47:0] lkp_vaddr_i = '0;
  logic        fill_valid_i = 1'b0;
  logic [47:0] fill_vaddr_i = '0;
  logic [39:0] fill_ppn_i = '0;
  logic        hit_o;
  logic [51:0] paddr_o;

  xlat_cache_top i_xlat_cache_top (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  string cur_req = "R2";

  // behavioural reference
  bit          m_v [16][8];
  logic [31:0] m_t [16][8];
  logic [39:0] m_p [16][8];
  logic [15:0] m_rnd;
  bit          e_hit;
  logic [51:0] e_pa;

  function automatic logic [47:0] va(input int set, input logic [31:0] tag, input logic [11:0] ofs);
    return {tag, 4'(set), ofs};
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 16; s++) for (int w = 0; w < 8; w++) m_v[s][w] = 0;
    m_rnd = 16'hACE1;
    e_hit = 0;
    e_pa  = '0;
  endtask

  task automatic check_out();
    checks++;
    if (hit_o !== e_hit || paddr_o !== e_pa) begin
      errors++;
      $display("FAIL %s: hit=%0b paddr=%h expected hit=%0b paddr=%h", cur_req, hit_o, paddr_o, e_hit, e_pa);
    end
  endtask

  task automatic step(input bit lv, input logic [47:0] la, input bit fv,
                      input logic [47:0] fa, input logic [39:0] fp, input bit fl);
    int s;
    int w;
    lkp_valid_i = lv; lkp_vaddr_i = la;
    fill_valid_i = fv; fill_vaddr_i = fa; fill_ppn_i = fp; flush_i = fl;
    // lookup on pre-edge contents
    e_hit = 0; e_pa = '0;
    if (lv) begin
      s = int'(la[15:12]);
      for (int i = 0; i < 8; i++)
        if (!e_hit && m_v[s][i] && m_t[s][i] == la[47:16]) begin
          e_hit = 1; e_pa = {m_p[s][i], la[11:0]};
        end
    end
    if (fl) begin
      for (int a = 0; a < 16; a++) for (int b = 0; b < 8; b++) m_v[a][b] = 0;
    end else if (fv && fp != '0) begin
      s = int'(fa[15:12]);
      w = -1;
      for (int i = 0; i < 8; i++) if (!m_v[s][i]) w = i;
      if (w < 0) w = int'(m_rnd[2:0]);
      m_v[s][w] = 1; m_t[s][w] = fa[47:16]; m_p[s][w] = fp;
    end
    m_rnd = {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
    @(negedge clk_i);
    check_out();
  endtask

  task automatic look(input logic [47:0] a);
    step(1, a, 0, '0, '0, 0);
  endtask

  task automatic fill(input logic [47:0] a, input logic [39:0] p);
    step(0, '0, 1, a, p, 0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    lkp_valid_i = 0; fill_valid_i = 0; flush_i = 0;
    model_reset();
    @(negedge clk_i);
    cur_req = "R6";
    check_out();
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL R2: watchdog expired, actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk_i);
    cur_req = "R6";
    check_out();
    rst_ni = 1;

    // R1 miss on empty array, then hit after a fill; R3 free way used
    cur_req = "R1";
    look(va(3, 32'hDEAD_0001, 12'h123));
    fill(va(3, 32'hDEAD_0001, 12'h000), 40'h12_3456_789A);
    cur_req = "R2";
    look(va(3, 32'hDEAD_0001, 12'hABC));
    step(0, '0, 0, '0, '0, 0);
    cur_req = "R1";
    look(va(4, 32'hDEAD_0001, 12'hABC));

    // R3 + R4: fill a set fully, then force random victims
    cur_req = "R3";
    for (int i = 0; i < 8; i++) fill(va(5, 32'h100 + i, 0), 40'h500 + i);
    for (int i = 0; i < 8; i++) look(va(5, 32'h100 + i, 12'(i)));
    cur_req = "R4";
    for (int k = 0; k < 6; k++) begin
      fill(va(5, 32'h200 + k, 0), 40'h900 + k);
      for (int i = 0; i < 8; i++) look(va(5, 32'h100 + i, 12'h7));
      for (int i = 0; i <= k; i++) look(va(5, 32'h200 + i, 12'h8));
    end

    // R5 zero page number dropped
    cur_req = "R5";
    fill(va(6, 32'hBEEF, 0), 40'h0);
    look(va(6, 32'hBEEF, 12'h1));

    // R8 same-cycle fill and lookup
    cur_req = "R8";
    step(1, va(7, 32'hCAFE, 12'h5), 1, va(7, 32'hCAFE, 0), 40'hC0FFEE, 0);
    look(va(7, 32'hCAFE, 12'h5));

    // R9 duplicate tags: lowest way wins
    cur_req = "R9";
    fill(va(8, 32'h77, 0), 40'hAAA);
    fill(va(8, 32'h77, 0), 40'hBBB);
    look(va(8, 32'h77, 12'hF0F));

    // R7 flush: lookup in flush cycle sees old, fill discarded, then empty
    cur_req = "R7";
    step(1, va(3, 32'hDEAD_0001, 12'h9), 1, va(9, 32'h55, 0), 40'h55, 1);
    look(va(3, 32'hDEAD_0001, 12'h9));
    look(va(9, 32'h55, 12'h9));
    look(va(8, 32'h77, 12'h9));

    // R6 reset mid-run
    fill(va(2, 32'h42, 0), 40'h42);
    cur_req = "R6";
    do_reset();
    look(va(2, 32'h42, 12'h1));

    // mixed traffic over two crowded sets
    cur_req = "R1";
    for (int n = 0; n < 4000; n++) begin
      automatic bit          lv = ($urandom_range(0, 3) != 0);
      automatic bit          fv = ($urandom_range(0, 2) == 0);
      automatic bit          fl = ($urandom_range(0, 299) == 0);
      automatic logic [47:0] la = va($urandom_range(0, 1), 32'($urandom_range(0, 11)), 12'($urandom));
      automatic logic [47:0] fa = va($urandom_range(0, 1), 32'($urandom_range(0, 11)), 12'($urandom));
      automatic logic [39:0] fp = ($urandom_range(0, 9) == 0) ? 40'h0 : 40'($urandom_range(1, 1000000));
      step(lv, la, fv, fa, fp, fl);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule